// File: doc/BRIEF.md
# Peripheral Module Stop Controller

This block holds one stop bit for every on-chip peripheral and turns those bits into per-module stop requests, register-access enables and state-retain flags. The stop bits sit in four 32-bit control words. Software reaches them through a small port with a 2-bit word select, a write enable, write data and combinational read data. Stopping a module takes effect at the next clock edge. A release is held back until the surrounding bus cycle ends, which an external strobe marks. A module that has just been stopped still accepts register accesses for one more cycle. After that, its registers are shut off from the bus until it is released again.

Each peripheral appears here as a single data register on a shared access port. This lets the stop and access rules be seen at the block's pins. When that register is blocked, reads return zero and writes are dropped without an error response. Stopping a module never clears its register, so the contents come back unchanged on release. Word bits that map to no module always read as 1 and cannot be changed.

Top module: `periph_stop_ctrl`

## Requirements
- R1: After reset every implemented module is stopped, except modules 27 and 28 (word 0, bits 27 and 28) and module 64 (word 2, bit 0). Word 0 reads 0xE7FFFFFF, word 2 reads 0xFFFFFFFE, and words 1 and 3 read 0xFFFFFFFF. All peripheral registers reset to 0.
- R2: A word write that sets a bit raises that module's stopReq at the next clock edge.
- R3: A word write that clears a bit changes the read-back value at once. stopReq stays high until the first cycle after the write cycle in which busCycleEnd is 1, and falls at that cycle's edge. A busCycleEnd in the write cycle itself does not release the module.
- R4: If a 1 is written to a bit whose release is still pending, the release is cancelled and the module stays stopped through later busCycleEnd pulses.
- R5: When accessEn is 0 for the addressed module, a peripheral read returns 0 and a peripheral write leaves the register unchanged.
- R6: In the single cycle after a module's stopReq rises, accessEn stays 1 and a peripheral write still lands. From the next cycle on, accesses are blocked.
- R7: A peripheral register keeps its value through a stop and release.
- R8: Word 3 bits 16 to 31 are unimplemented. They read as 1, keep stopReq at 1, and ignore writes.
- R9: retain is 1 exactly when a module is stopped and not in its grace cycle. accessEn is 1 when the module is running or in its grace cycle.
- R10: cfgSel value n selects word n (0 to 3), and bit i of word n controls module 32*n+i. The module number is the value on perIdx.

Ports:
## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| cfgWe | input | 1 | Stop-word write enable |
| cfgSel | input | 2 | Stop-word select |
| cfgWdata | input | 32 | Stop-word write data |
| cfgRdata | output | 32 | Selected stop word as last written |
| busCycleEnd | input | 1 | End-of-bus-cycle strobe that applies pending releases |
| perReq | input | 1 | Peripheral register access request |
| perWe | input | 1 | Peripheral access is a write |
| perIdx | input | 7 | Addressed module number |
| perWdata | input | 8 | Peripheral write data |
| perRdata | output | 8 | Peripheral read data, zero when blocked |
| stopReq | output | 128 | Per-module stop request |
| accessEn | output | 128 | Per-module register access enable |
| retain | output | 128 | Per-module state-retain indication |

## Verification
The bench targets three timing hazards:
- A clear written in the same cycle as busCycleEnd. A design that counts that strobe would release the module one bus cycle early.
- A set that arrives while a release is pending. A design that forgets to cancel the release would restart a module that software had just stopped again.
- The grace window. A window that is missing would drop the write that arrives right after a stop. A window that lasts too long would let a later write corrupt the retained register.

The bench also checks the unimplemented bits, and it checks that blocked reads return zero rather than stale data.

// File: rtl/periph_stop_pkg.sv
package periph_stop_pkg;
  localparam int NUM_REGS = 4;
  localparam int REG_W    = 32;
  localparam int NUM_MODS = NUM_REGS * REG_W;
  localparam int SEL_W    = $clog2(NUM_REGS);
  localparam int IDX_W    = $clog2(NUM_MODS);

  // strobes from control to the stop-word datapath and the peripheral bank
  typedef struct packed {
    logic [NUM_REGS-1:0] regWr;    // one-hot stop-word write
    logic                modWr;    // granted peripheral write
    logic                modRdOk;  // granted peripheral read
  } stop_strobe_t;
endpackage

// File: rtl/periph_stop_ctl.sv
module periph_stop_ctl
  import periph_stop_pkg::*;
(
  input  logic                cfgWe,
  input  logic [SEL_W-1:0]    cfgSel,
  input  logic                perReq,
  input  logic                perWe,
  input  logic [IDX_W-1:0]    perIdx,
  input  logic [NUM_MODS-1:0] accessEn,
  output stop_strobe_t        stb
);
  logic granted;

  assign granted = accessEn[perIdx];

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_sel
    assign stb.regWr[r] = cfgWe && (cfgSel == SEL_W'(r));
  end

  assign stb.modWr   = perReq &&  perWe && granted;
  assign stb.modRdOk = perReq && !perWe && granted;
endmodule

// File: rtl/periph_stop_dp.sv
module periph_stop_dp
  import periph_stop_pkg::*;
#(
  parameter logic [NUM_MODS-1:0] IMPL_MASK = {16'h0000, {(NUM_MODS-16){1'b1}}},
  parameter logic [NUM_MODS-1:0] RST_STOP  = 128'hFFFFFFFF_FFFFFFFE_FFFFFFFF_E7FFFFFF
) (
  input  logic                clk,
  input  logic                rstN,
  input  stop_strobe_t        stb,
  input  logic [SEL_W-1:0]    cfgSel,
  input  logic [REG_W-1:0]    cfgWdata,
  input  logic                busCycleEnd,
  output logic [REG_W-1:0]    cfgRdata,
  output logic [NUM_MODS-1:0] stopReq,
  output logic [NUM_MODS-1:0] accessEn,
  output logic [NUM_MODS-1:0] retain
);
  localparam logic [NUM_MODS-1:0] RST_VAL = RST_STOP | ~IMPL_MASK;

  logic [NUM_MODS-1:0] reqBits, stopBits, stopDly;
  logic [NUM_MODS-1:0] wrEn, wrData, setNow, reqNext, stopNext, relNow, grace;

  // spread the one-hot word write across the flat module vector
  for (genvar r = 0; r < NUM_REGS; r++) begin : g_word
    assign wrEn[r*REG_W +: REG_W]   = {REG_W{stb.regWr[r]}};
    assign wrData[r*REG_W +: REG_W] = cfgWdata;
  end

  always_comb begin
    setNow   = wrEn & wrData & IMPL_MASK;
    reqNext  = (wrEn & (wrData | ~IMPL_MASK)) | (~wrEn & reqBits);
    // release only for bits whose request was already 0 before this cycle
    relNow   = {NUM_MODS{busCycleEnd}} & ~reqBits;
    stopNext = setNow | (stopBits & ~relNow) | ~IMPL_MASK;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqBits  <= RST_VAL;
      stopBits <= RST_VAL;
      stopDly  <= RST_VAL;
    end else begin
      reqBits  <= reqNext;
      stopBits <= stopNext;
      stopDly  <= stopBits;
    end
  end

  assign grace    = stopBits & ~stopDly;
  assign stopReq  = stopBits;
  assign accessEn = ~stopBits | grace;
  assign retain   = stopBits & ~grace;
  assign cfgRdata = reqBits[int'(cfgSel)*REG_W +: REG_W];

  // a running module only comes back after a bus-cycle-end strobe
  assert_release_on_bus_end_R3: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(stopBits) & ~stopBits)) |-> $past(busCycleEnd));

  // the grace window never spans two consecutive cycles
  assert_grace_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    ((accessEn & stopBits & $past(accessEn & stopBits)) == '0));

  for (genvar r = 0; r < NUM_REGS; r++) begin : g_chk
    assert_set_next_edge_R2: assert property (@(posedge clk) disable iff (!rstN)
      stb.regWr[r] |=> ((stopBits[r*REG_W +: REG_W] & $past(cfgWdata)) == $past(cfgWdata)));
  end
endmodule

// File: rtl/periph_stop_models.sv
module periph_stop_models
  import periph_stop_pkg::*;
#(
  parameter int DAT_W = 8
) (
  input  logic             clk,
  input  logic             rstN,
  input  stop_strobe_t     stb,
  input  logic [IDX_W-1:0] perIdx,
  input  logic [DAT_W-1:0] perWdata,
  output logic [DAT_W-1:0] perRdata
);
  logic [DAT_W-1:0] modRegs [NUM_MODS];

  for (genvar m = 0; m < NUM_MODS; m++) begin : g_mod
    always_ff @(posedge clk) begin
      if (!rstN)
        modRegs[m] <= '0;
      else if (stb.modWr && perIdx == IDX_W'(m))
        modRegs[m] <= perWdata;
    end
  end

  assign perRdata = stb.modRdOk ? modRegs[perIdx] : '0;
endmodule

// File: rtl/periph_stop_ctrl.sv
module periph_stop_ctrl
  import periph_stop_pkg::*;
#(
  parameter logic [NUM_MODS-1:0] IMPL_MASK = {16'h0000, {(NUM_MODS-16){1'b1}}},
  parameter logic [NUM_MODS-1:0] RST_STOP  = 128'hFFFFFFFF_FFFFFFFE_FFFFFFFF_E7FFFFFF,
  parameter int                  DAT_W     = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cfgWe,
  input  logic [SEL_W-1:0]    cfgSel,
  input  logic [REG_W-1:0]    cfgWdata,
  output logic [REG_W-1:0]    cfgRdata,
  input  logic                busCycleEnd,
  input  logic                perReq,
  input  logic                perWe,
  input  logic [IDX_W-1:0]    perIdx,
  input  logic [DAT_W-1:0]    perWdata,
  output logic [DAT_W-1:0]    perRdata,
  output logic [NUM_MODS-1:0] stopReq,
  output logic [NUM_MODS-1:0] accessEn,
  output logic [NUM_MODS-1:0] retain
);
  stop_strobe_t stb;

  periph_stop_ctl u_ctl (
    .cfgWe(cfgWe), .cfgSel(cfgSel), .perReq(perReq), .perWe(perWe),
    .perIdx(perIdx), .accessEn(accessEn), .stb(stb)
  );

  periph_stop_dp #(.IMPL_MASK(IMPL_MASK), .RST_STOP(RST_STOP)) u_dp (
    .clk(clk), .rstN(rstN), .stb(stb), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .busCycleEnd(busCycleEnd), .cfgRdata(cfgRdata), .stopReq(stopReq),
    .accessEn(accessEn), .retain(retain)
  );

  periph_stop_models #(.DAT_W(DAT_W)) u_models (
    .clk(clk), .rstN(rstN), .stb(stb), .perIdx(perIdx),
    .perWdata(perWdata), .perRdata(perRdata)
  );

  // a blocked read must never leak register contents
  assert_blocked_read_zero_R5: assert property (@(posedge clk) disable iff (!rstN)
    (perReq && !perWe && !accessEn[perIdx]) |-> (perRdata == '0));
endmodule

// File: tb/periph_stop_ctrl_bench.sv
`timescale 1ns/1ps
module periph_stop_ctrl_bench;
  localparam logic [2:0] K_IDLE = 3'd0, K_CWR = 3'd1, K_CRD = 3'd2, K_PWR = 3'd3,
                         K_PRD = 3'd4, K_STP = 3'd5, K_RET = 3'd6;

  typedef struct packed {
    logic [2:0]  kind;
    logic        bend;
    logic [1:0]  sel;
    logic [6:0]  idx;
    logic [31:0] data;   // write data or expected value
  } vec_t;

  localparam int NV = 41;
  localparam vec_t VECS [NV] = '{
    '{K_CRD, 1'b0, 2'd0, 7'd0,  32'hE7FFFFFF},  // 0  R1 word 0 reset
    '{K_CRD, 1'b0, 2'd2, 7'd0,  32'hFFFFFFFE},  // 1  R1 word 2 reset
    '{K_CRD, 1'b0, 2'd3, 7'd0,  32'hFFFFFFFF},  // 2  R1 R8 word 3 reset
    '{K_STP, 1'b0, 2'd0, 7'd0,  32'hE7FFFFFF},  // 3  R1 stopReq at reset
    '{K_PWR, 1'b0, 2'd0, 7'd27, 32'h0000005A},  // 4  always-on write
    '{K_PRD, 1'b0, 2'd0, 7'd27, 32'h0000005A},  // 5  R10 R5 always-on reads back
    '{K_PWR, 1'b0, 2'd0, 7'd5,  32'h00000033},  // 6  write to stopped module
    '{K_PRD, 1'b0, 2'd0, 7'd5,  32'h00000000},  // 7  R5 blocked read zero
    '{K_CWR, 1'b0, 2'd0, 7'd0,  32'hE7FFFFDF},  // 8  clear bit 5
    '{K_CRD, 1'b0, 2'd0, 7'd0,  32'hE7FFFFDF},  // 9  R3 read-back immediate
    '{K_STP, 1'b0, 2'd0, 7'd0,  32'hE7FFFFFF},  // 10 R3 still stopped
    '{K_PWR, 1'b0, 2'd0, 7'd5,  32'h00000099},  // 11 write while release pending
    '{K_IDLE,1'b1, 2'd0, 7'd0,  32'h00000000},  // 12 bus cycle ends
    '{K_STP, 1'b0, 2'd0, 7'd0,  32'hE7FFFFDF},  // 13 R3 released
    '{K_PRD, 1'b0, 2'd0, 7'd5,  32'h00000000},  // 14 R5 blocked writes dropped
    '{K_PWR, 1'b0, 2'd0, 7'd5,  32'h00000033},  // 15
    '{K_PRD, 1'b0, 2'd0, 7'd5,  32'h00000033},  // 16 running access
    '{K_CWR, 1'b0, 2'd0, 7'd0,  32'hE7FFFFFF},  // 17 stop module 5
    '{K_PWR, 1'b0, 2'd0, 7'd5,  32'h00000044},  // 18 R6 grace write
    '{K_RET, 1'b0, 2'd0, 7'd0,  32'hE7FFFFFF},  // 19 R9 retain after grace
    '{K_PRD, 1'b0, 2'd0, 7'd5,  32'h00000000},  // 20 R5 stopped read
    '{K_CWR, 1'b1, 2'd0, 7'd0,  32'hE7FFFFDF},  // 21 clear with same-cycle strobe
    '{K_STP, 1'b0, 2'd0, 7'd0,  32'hE7FFFFFF},  // 22 R3 same-cycle strobe ignored
    '{K_IDLE,1'b1, 2'd0, 7'd0,  32'h00000000},  // 23
    '{K_PRD, 1'b0, 2'd0, 7'd5,  32'h00000044},  // 24 R7 R6 retained grace data
    '{K_CWR, 1'b0, 2'd0, 7'd0,  32'hE7FFFFFF},  // 25 stop again
    '{K_IDLE,1'b0, 2'd0, 7'd0,  32'h00000000},  // 26 grace cycle unused
    '{K_PWR, 1'b0, 2'd0, 7'd5,  32'h00000077},  // 27 late write, blocked
    '{K_CWR, 1'b0, 2'd0, 7'd0,  32'hE7FFFFDF},  // 28
    '{K_IDLE,1'b1, 2'd0, 7'd0,  32'h00000000},  // 29
    '{K_PRD, 1'b0, 2'd0, 7'd5,  32'h00000044},  // 30 R6 R7 window was one cycle
    '{K_CWR, 1'b0, 2'd3, 7'd0,  32'h00000000},  // 31 clear all of word 3
    '{K_CRD, 1'b0, 2'd3, 7'd0,  32'hFFFF0000},  // 32 R8 unimplemented read 1
    '{K_IDLE,1'b1, 2'd0, 7'd0,  32'h00000000},  // 33
    '{K_STP, 1'b0, 2'd3, 7'd0,  32'hFFFF0000},  // 34 R8 unimplemented stay stopped
    '{K_CWR, 1'b0, 2'd1, 7'd0,  32'hFFFFFFFE},  // 35 clear module 32
    '{K_CWR, 1'b0, 2'd1, 7'd0,  32'hFFFFFFFF},  // 36 set again before strobe
    '{K_IDLE,1'b1, 2'd0, 7'd0,  32'h00000000},  // 37
    '{K_STP, 1'b0, 2'd1, 7'd0,  32'hFFFFFFFF},  // 38 R4 release cancelled
    '{K_CWR, 1'b0, 2'd0, 7'd0,  32'hF7FFFFDF},  // 39 stop always-on module 28
    '{K_STP, 1'b0, 2'd0, 7'd0,  32'hF7FFFFDF}   // 40 R2 stopped next edge
  };

  logic         clk = 1'b0;
  logic         rstN;
  logic         cfgWe, busCycleEnd, perReq, perWe;
  logic [1:0]   cfgSel;
  logic [31:0]  cfgWdata, cfgRdata;
  logic [6:0]   perIdx;
  logic [7:0]   perWdata, perRdata;
  logic [127:0] stopReq, accessEn, retain;

  int  nChecks = 0;
  int  nFail   = 0;
  bit  done    = 1'b0;

  always #4 clk = ~clk;

  periph_stop_ctrl u_periph_stop_ctrl (
    .clk(clk), .rstN(rstN), .cfgWe(cfgWe), .cfgSel(cfgSel), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .busCycleEnd(busCycleEnd), .perReq(perReq), .perWe(perWe),
    .perIdx(perIdx), .perWdata(perWdata), .perRdata(perRdata), .stopReq(stopReq),
    .accessEn(accessEn), .retain(retain)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic idleInputs();
    cfgWe = 1'b0; cfgSel = '0; cfgWdata = '0; busCycleEnd = 1'b0;
    perReq = 1'b0; perWe = 1'b0; perIdx = '0; perWdata = '0;
  endtask

  task automatic finishRun();
    if (!done) begin
      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", nChecks, nFail);
      $finish;
    end
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0;
    idleInputs();
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      idleInputs();
      busCycleEnd = VECS[i].bend;
      cfgSel = VECS[i].sel;
      perIdx = VECS[i].idx;
      case (VECS[i].kind)
        K_CWR: begin cfgWe = 1'b1; cfgWdata = VECS[i].data; end
        K_PWR: begin perReq = 1'b1; perWe = 1'b1; perWdata = VECS[i].data[7:0]; end
        K_PRD: perReq = 1'b1;
        default: ;
      endcase
      #2;
      case (VECS[i].kind)
        K_CRD: check($sformatf("vec %0d cfg read", i), cfgRdata, VECS[i].data);
        K_PRD: check($sformatf("vec %0d periph read", i), {24'h0, perRdata}, VECS[i].data);
        K_STP: check($sformatf("vec %0d stopReq", i),
                     stopReq[int'(VECS[i].sel)*32 +: 32], VECS[i].data);
        K_RET: check($sformatf("vec %0d retain", i),
                     retain[int'(VECS[i].sel)*32 +: 32], VECS[i].data);
        default: ;
      endcase
    end

    // R9: module 28 stopped past its grace cycle
    @(negedge clk); idleInputs(); #2;
    check("R9 accessEn[28] stopped", {31'h0, accessEn[28]}, 32'h0);
    check("R9 retain[28] stopped", {31'h0, retain[28]}, 32'h1);

    // R6 R9: grace cycle seen on the status outputs
    @(negedge clk); cfgWe = 1'b1; cfgSel = 2'd0; cfgWdata = 32'hF7FFFFFF;
    @(negedge clk); idleInputs(); #2;
    check("R6 accessEn[5] in grace", {31'h0, accessEn[5]}, 32'h1);
    check("R9 retain[5] in grace", {31'h0, retain[5]}, 32'h0);
    check("R2 stopReq[5] set", {31'h0, stopReq[5]}, 32'h1);
    @(negedge clk); #2;
    check("R6 accessEn[5] after grace", {31'h0, accessEn[5]}, 32'h0);
    check("R9 retain[5] after grace", {31'h0, retain[5]}, 32'h1);

    // R1: reset again restores defaults
    @(negedge clk); rstN = 1'b0;
    @(negedge clk); @(negedge clk); rstN = 1'b1; #2;
    check("R1 word 0 after reset", cfgRdata, 32'hE7FFFFFF);
    check("R1 stopReq[28] after reset", {31'h0, stopReq[28]}, 32'h0);
    check("R1 stopReq[64] after reset", {31'h0, stopReq[64]}, 32'h0);
    perReq = 1'b1; perIdx = 7'd27; #1;
    check("R1 periph reg cleared", {24'h0, perRdata}, 32'h0);
    @(negedge clk); idleInputs();
    finishRun();
  end
endmodule